// File: doc/BRIEF.md
# Stereo I2S Master Serial Audio Controller

This block connects a processor bus to a stereo serial audio link on which it always drives the bit clock and word select itself. Software sets the sample width, the framing and the clock and word-select polarities through a configuration register. It then powers the link up through a separate enable register. Transmit samples are written one at a time to a data port. They queue in a small transmit FIFO and go out as left/right pairs. Received slots are gathered into a receive FIFO that software drains through the same data port.

The master clock `mclk` is taken to run at 256 times the sample rate. Each channel occupies a 32-bit slot, so the bit clock is `mclk` divided by four and one stereo frame spans 256 `mclk` cycles. Samples narrower than the slot are zero-padded according to the framing mode. Four sticky error flags record FIFO underflow and overflow on both paths. Writing a one to a flag clears it. An internal loopback feeds the serial transmit stream straight into the receiver. A pin-release option stops the block from driving the data line.

Top module: `i2s_master_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x0000_0010 (width 16, I2S framing, all options off) and the enable register reads 0x2. `i2s_bclk`, `i2s_ws` and `i2s_sdo_oe` are low. `reg_addr` is a word index: 0 is the data port, 1 the configuration and 2 the enable register.
- R2: The serial engine runs only while the enable register holds 0b01 (bit 0 clock enable set, bit 1 disable clear). With any other value, bit clock and word select sit at their idle levels, the data output is not driven and the frame position is held.
- R3: While running, the raw bit clock has a period of 4 `mclk` cycles. The raw word select is low for the 128-cycle left slot and high for the 128-cycle right slot. Each slot carries 32 bit-clock rising edges.
- R4: Configuration bits [8:7] select the framing: 0 = I2S (MSB in the second bit of the slot), 1 = left-justified (MSB in the first bit), 2 = right-justified (LSB in the last bit). Every other slot bit is 0, and bits go out MSB first.
- R5: Configuration bits [4:0] hold the sample width. A write whose width is not 8, 16, 18, 20 or 24 leaves the width unchanged, and a write of framing code 3 leaves the framing unchanged. The other fields of that write still take effect.
- R6: Bit 12 inverts the bit clock and bit 9 inverts the word select. Each acts alone on its own pin, both when idle and when running.
- R7: After power-up the first transmit FIFO word goes to the left slot and the words then alternate left/right. A sample is taken from the low `width` bits of the data word.
- R8: When a slot starts with the transmit FIFO enabled and empty, the slot carries zeros and the transmit-underflow flag (bit 25) is set.
- R9: A data-port write with the transmit FIFO full (4 words) is dropped and sets the transmit-overflow flag (bit 24).
- R10: Each received slot is pushed into the receive FIFO right-aligned and zero-extended. A data-port read returns and pops the oldest word. A read while the receive FIFO is empty returns 0 and sets the receive-underflow flag (bit 23).
- R11: A received slot that finds the receive FIFO full (4 words) is dropped and sets the receive-overflow flag (bit 22).
- R12: Bit 10 routes the internal transmit bit into the receiver and ignores `i2s_sdi`. Bit 11 deasserts `i2s_sdo_oe` and forces `i2s_sdo` low, and reception from `i2s_sdi` continues.
- R13: Bit 6 enables the transmit FIFO and bit 5 the receive FIFO. A disabled FIFO is empty and drops pushes without setting any flag. A disabled transmit path sends zeros without an underflow.
- R14: The four flags stay set until a configuration write carries a 1 in the flag's bit position. Writing 0 there leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at word 0) |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| i2s_bclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select (channel) |
| i2s_sdo | output | 1 | Serial transmit data |
| i2s_sdo_oe | output | 1 | Drive enable for the data line |
| i2s_sdi | input | 1 | Serial receive data |

## Verification
The hardest state to reach is receive overflow coinciding with transmit underflow while the serial stream is still bit-exact. Reaching it needs a full frame sequence in which the transmit FIFO drains before the receive FIFO fills. Each run therefore preloads one to four samples and then lets seven slots elapse with loopback or an external wire from `i2s_sdo` to `i2s_sdi`. A port-side monitor rebuilds each 32-bit slot from the rising bit-clock edges, correcting for the selected polarities. The bench then compares the slot stream, the received words and all four flags with values computed from the framing rules. Runs with `i2s_sdi` held constant separate internal loopback from external reception.

// File: rtl/i2s_master_ctrl.sv
module i2s_master_ctrl #(
  parameter int FIFO_DEPTH     = 4,
  parameter int SLOT_BITS      = 32,
  parameter int MCLK_PER_FRAME = 256,
  parameter int MAX_W          = 24
) (
  input  logic        mclk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        i2s_bclk,
  output logic        i2s_ws,
  output logic        i2s_sdo,
  output logic        i2s_sdo_oe,
  input  logic        i2s_sdi
);
  localparam int BIT_CLKS = MCLK_PER_FRAME / (2 * SLOT_BITS);
  localparam int CNT_W    = $clog2(MCLK_PER_FRAME);
  localparam int PH_W     = $clog2(BIT_CLKS);
  localparam int BSEL_W   = $clog2(MAX_W);
  localparam int PW       = $clog2(FIFO_DEPTH);
  localparam logic [PW:0] FULL = (PW+1)'(FIFO_DEPTH);
  localparam logic [PH_W-1:0] SAMPLE_PH = PH_W'(BIT_CLKS / 2);

  logic [4:0]  width;
  logic [1:0]  frame;
  logic        ws_inv, ck_inv, loop_en, pin_in, tx_en, rx_en;
  logic [3:0]  flags;
  logic [1:0]  en_reg;
  logic [CNT_W-1:0] cnt;
  logic        primed;
  logic [MAX_W-1:0] cur_tx, rx_acc;
  logic [MAX_W-1:0] txq [FIFO_DEPTH];
  logic [MAX_W-1:0] rxq [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [PW:0]   tx_cnt, rx_cnt;
  logic          slot_valid;
  logic [BSEL_W-1:0] bitsel;
  logic          unused_wbits;

  function automatic logic width_ok(input logic [4:0] w);
    return w inside {5'd8, 5'd16, 5'd18, 5'd20, 5'd24};
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire run    = en_reg == 2'b01;
  wire wr_dat = reg_wr && reg_addr == 2'd0;
  wire wr_cfg = reg_wr && reg_addr == 2'd1;
  wire wr_en  = reg_wr && reg_addr == 2'd2;
  wire rd_dat = reg_rd && reg_addr == 2'd0;

  wire [PH_W-1:0] phase = cnt[PH_W-1:0];
  wire [CNT_W-2-PH_W:0] pos = cnt[CNT_W-2:PH_W];
  wire ch   = cnt[CNT_W-1];
  wire evt  = run && (cnt[CNT_W-2:0] == '1);
  wire samp = run && (phase == SAMPLE_PH);

  always_comb begin
    int off, rel;
    case (frame)
      2'd1:    off = 0;
      2'd2:    off = SLOT_BITS - int'(width);
      default: off = 1;
    endcase
    rel = int'(pos) - off;
    slot_valid = (rel >= 0) && (rel < int'(width));
    bitsel = slot_valid ? BSEL_W'(int'(width) - 1 - rel) : '0;
  end

  wire tx_bit = slot_valid & cur_tx[bitsel];
  wire din    = loop_en ? tx_bit : i2s_sdi;

  assign i2s_bclk   = (run & phase[PH_W-1]) ^ ck_inv;
  assign i2s_ws     = (run & ch) ^ ws_inv;
  assign i2s_sdo_oe = run & ~pin_in;
  assign i2s_sdo    = i2s_sdo_oe & tx_bit;

  wire tx_push = wr_dat && tx_en && tx_cnt != FULL;
  wire tx_ovf  = wr_dat && tx_en && tx_cnt == FULL;
  wire tx_pop  = evt && tx_en && tx_cnt != '0;
  wire tx_unf  = evt && tx_en && tx_cnt == '0;
  wire rx_try  = evt && primed && rx_en;
  wire rx_push = rx_try && rx_cnt != FULL;
  wire rx_ovf  = rx_try && rx_cnt == FULL;
  wire rx_pop  = rd_dat && rx_cnt != '0;
  wire rx_unf  = rd_dat && rx_cnt == '0;
  wire [3:0] flag_set = {tx_unf, tx_ovf, rx_unf, rx_ovf};

  assign unused_wbits = ^{reg_wdata[31:26], reg_wdata[21:13]};

  always_ff @(posedge mclk) begin
    if (tx_push) txq[tx_wp] <= reg_wdata[MAX_W-1:0];
    if (rx_push) rxq[rx_wp] <= rx_acc;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      width <= 5'd16; frame <= 2'd0;
      {ws_inv, ck_inv, loop_en, pin_in, tx_en, rx_en} <= '0;
      flags <= '0; en_reg <= 2'b10; cnt <= '1; primed <= 1'b0;
      cur_tx <= '0; rx_acc <= '0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (wr_cfg) begin
        if (width_ok(reg_wdata[4:0])) width <= reg_wdata[4:0];
        if (reg_wdata[8:7] != 2'd3)   frame <= reg_wdata[8:7];
        ws_inv  <= reg_wdata[9];
        loop_en <= reg_wdata[10];
        pin_in  <= reg_wdata[11];
        ck_inv  <= reg_wdata[12];
        tx_en   <= reg_wdata[6];
        rx_en   <= reg_wdata[5];
      end
      flags  <= (wr_cfg ? flags & ~reg_wdata[25:22] : flags) | flag_set;
      if (wr_en) en_reg <= reg_wdata[1:0];
      cnt    <= run ? cnt + 1'b1 : '1;
      primed <= run & (primed | evt);
      if (evt) cur_tx <= tx_pop ? txq[tx_rp] : '0;
      if (!run || evt)              rx_acc <= '0;
      else if (samp && slot_valid)  rx_acc[bitsel] <= din;
      if (!tx_en) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= nxt(tx_wp);
        if (tx_pop)  tx_rp <= nxt(tx_rp);
        tx_cnt <= tx_cnt + {{PW{1'b0}}, tx_push} - {{PW{1'b0}}, tx_pop};
      end
      if (!rx_en) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_push) rx_wp <= nxt(rx_wp);
        if (rx_pop)  rx_rp <= nxt(rx_rp);
        rx_cnt <= rx_cnt + {{PW{1'b0}}, rx_push} - {{PW{1'b0}}, rx_pop};
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = (rx_cnt != '0) ? {{(32-MAX_W){1'b0}}, rxq[rx_rp]} : '0;
      2'd1:    reg_rdata = {6'b0, flags, 9'b0, ck_inv, pin_in, loop_en, ws_inv,
                            frame, tx_en, rx_en, width};
      2'd2:    reg_rdata = {30'b0, en_reg};
      default: reg_rdata = '0;
    endcase
  end

  assert_hold_when_off_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    !run |=> (&cnt));
  assert_bit_advance_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) + 1'b1));
  assert_legal_fields_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    width_ok(width) && frame != 2'd3);
  assert_zero_on_underflow_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    (evt && tx_en && tx_cnt == '0) |=> (cur_tx == '0 && flags[3]));
  assert_no_overflow_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    tx_cnt <= FULL);
  assert_no_overflow_R11: assert property (@(posedge mclk) disable iff (!rst_n)
    rx_cnt <= FULL);
  assert_sticky_flags_R14: assert property (@(posedge mclk) disable iff (!rst_n)
    !wr_cfg |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/i2s_master_ctrl_tb.sv
`timescale 1ns/1ps
module i2s_master_ctrl_tb_top;
  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic i2s_bclk, i2s_ws, i2s_sdo, i2s_sdo_oe, i2s_sdi;
  logic sdi_val, ext_loop;

  always #4 mclk = ~mclk;
  assign i2s_sdi = ext_loop ? i2s_sdo : sdi_val;

  i2s_master_ctrl dut_i (
    .mclk(mclk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sdo(i2s_sdo),
    .i2s_sdo_oe(i2s_sdo_oe), .i2s_sdi(i2s_sdi));

  int nchk = 0, nfail = 0;
  logic b_ck = 0, b_ws = 0, m_prev_b = 1, m_prev_ws = 1;
  int m_pos = 0, cap_n = 0, rises = 0;
  logic [31:0] m_bits = '0;
  logic [31:0] cap [16];

  always @(negedge mclk) begin
    logic br, wsr;
    br  = i2s_bclk ^ b_ck;
    wsr = i2s_ws ^ b_ws;
    if (br && !m_prev_b) begin
      rises++;
      if (wsr != m_prev_ws) m_pos = 0; else m_pos++;
      m_prev_ws = wsr;
      if (m_pos < 32) m_bits[31-m_pos] = i2s_sdo;
      if (m_pos == 31 && cap_n < 16) begin cap[cap_n] = m_bits; cap_n++; end
    end
    m_prev_b = br;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    nchk++;
    if (act !== exp_v) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge mclk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge mclk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge mclk); reg_rd = 1; reg_addr = a; #1; d = reg_rdata;
    @(negedge mclk); reg_rd = 0;
  endtask

  task automatic mon_reset(input logic ck, input logic ws);
    @(posedge mclk);
    b_ck = ck; b_ws = ws; m_prev_b = 1; m_prev_ws = 1; m_pos = 0; cap_n = 0;
  endtask

  task automatic count_toggles(output int n);
    logic p;
    n = 0; p = i2s_bclk;
    repeat (40) begin @(negedge mclk); if (i2s_bclk !== p) n++; p = i2s_bclk; end
  endtask

  function automatic logic [31:0] cfgw(input int mode, input int w,
      input bit ck, ws, loop, pin, txen, rxen);
    return (32'(ck) << 12) | (32'(pin) << 11) | (32'(loop) << 10) | (32'(ws) << 9) |
           (32'(mode) << 7) | (32'(txen) << 6) | (32'(rxen) << 5) | 32'(w);
  endfunction

  function automatic logic [31:0] exp_slot(input logic [23:0] s, input int w, input int mode);
    logic [31:0] r;
    int off;
    r = '0;
    off = (mode == 1) ? 0 : (mode == 2) ? 32 - w : 1;
    for (int p = 0; p < 32; p++) begin
      int rel;
      rel = p - off;
      if (rel >= 0 && rel < w) r[31-p] = s[w-1-rel];
    end
    return r;
  endfunction

  function automatic logic [31:0] mask(input int w);
    return 32'((64'd1 << w) - 1);
  endfunction

  task automatic run_case(input int mode, input int w, input bit ck, ws, loop, pin,
                          txen, rxen, sv, xl, input int npush, input bit meas);
    logic [23:0] s [4];
    logic [31:0] d, ex, src;
    int t, n, r0;
    wr_reg(2, 32'h2);
    wr_reg(1, 32'h03C0_0000 | 32'(w));
    wr_reg(1, cfgw(mode, w, ck, ws, loop, pin, txen, rxen));
    sdi_val = sv; ext_loop = xl;
    mon_reset(ck, ws);
    for (int k = 0; k < 4; k++) s[k] = 24'($urandom);
    for (int k = 0; k < npush; k++) wr_reg(0, {8'($urandom), s[k]});
    wr_reg(2, 32'h3);
    wr_reg(2, 32'h1);
    if (meas) begin
      do @(negedge mclk); while ((i2s_ws ^ b_ws) !== 1'b1);
      n = 0; r0 = rises;
      do begin @(negedge mclk); n++; end while ((i2s_ws ^ b_ws) === 1'b1);
      chk("R3 right slot length", 32'(n), 32'd128);
      chk("R3 bit clocks per slot", 32'(rises - r0), 32'd32);
    end
    t = 0;
    while (cap_n < 6 && t < 5000) begin @(negedge mclk); t++; end
    if (t >= 5000) chk("R7 slot capture timeout", 32'(cap_n), 32'd6);
    chk("R12 data output enable", {31'b0, i2s_sdo_oe}, {31'b0, !pin});
    repeat (4) @(posedge mclk);
    wr_reg(2, 32'h2);
    for (int k = 0; k < 6; k++) begin
      ex = (txen && k < npush && !pin) ? exp_slot(s[k], w, mode) : 32'h0;
      if (pin) chk("R12 released pin slot", cap[k], ex);
      else if (txen && k < npush) chk("R4 R7 slot content", cap[k], ex);
      else chk("R8 R13 zero slot", cap[k], ex);
    end
    rd_reg(1, d);
    chk("R8 R11 R13 flags", (d >> 22) & 32'hF, {28'b0, txen, 1'b0, 1'b0, rxen});
    for (int k = 0; k < (rxen ? 4 : 0); k++) begin
      src = (txen && k < npush) ? {8'b0, s[k]} : 32'h0;
      if (loop || (xl && !pin)) ex = src & mask(w);
      else if (xl) ex = 32'h0;
      else ex = sv ? mask(w) : 32'h0;
      rd_reg(0, d);
      chk("R10 R12 received word", d, ex);
    end
    rd_reg(0, d);
    chk("R10 empty read value", d, 32'h0);
    rd_reg(1, d);
    chk("R10 rx underflow flag", (d >> 23) & 32'h1, 32'h1);
  endtask

  initial begin
    #1200000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    int wl [5];
    wl = '{8, 16, 18, 20, 24};
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; sdi_val = 0; ext_loop = 0;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge mclk);
    rst_n = 1;

    rd_reg(1, d); chk("R1 cfg reset", d, 32'h0000_0010);
    rd_reg(2, d); chk("R1 enable reset", d, 32'h2);
    chk("R1 idle pins", {29'b0, i2s_bclk, i2s_ws, i2s_sdo_oe}, 32'h0);

    wr_reg(1, 32'h0000_018C); rd_reg(1, d); chk("R5 illegal width and framing", d, 32'h10);
    wr_reg(1, 32'h0000_0114); rd_reg(1, d); chk("R5 legal write", d, 32'h114);
    wr_reg(1, 32'h0000_0091); rd_reg(1, d); chk("R5 width kept framing taken", d, 32'h94);

    wr_reg(1, 32'h0000_1210); @(negedge mclk);
    chk("R6 both inverted idle", {30'b0, i2s_bclk, i2s_ws}, 32'h3);
    wr_reg(1, 32'h0000_1010); @(negedge mclk);
    chk("R6 clock only inverted", {30'b0, i2s_bclk, i2s_ws}, 32'h2);
    wr_reg(1, 32'h0000_0210); @(negedge mclk);
    chk("R6 word select only inverted", {30'b0, i2s_bclk, i2s_ws}, 32'h1);

    wr_reg(1, 32'h0000_0050);
    for (int k = 0; k < 5; k++) wr_reg(0, 32'h1000 + 32'(k));
    rd_reg(1, d); chk("R9 tx overflow flag", d, 32'h0100_0050);
    rd_reg(0, d); chk("R10 empty rx read", d, 32'h0);
    rd_reg(1, d); chk("R10 rx underflow set", d, 32'h0180_0050);
    wr_reg(1, 32'h0100_0050); rd_reg(1, d); chk("R14 clear one flag", d, 32'h0080_0050);
    wr_reg(1, 32'h0000_0050); rd_reg(1, d); chk("R14 zero keeps flag", d, 32'h0080_0050);
    wr_reg(1, 32'h0080_0050); rd_reg(1, d); chk("R14 clear last flag", d, 32'h0000_0050);

    wr_reg(1, 32'h0000_0010);
    wr_reg(2, 32'h3); count_toggles(n); chk("R2 disable with clock enable", 32'(n), 32'd0);
    chk("R2 no drive when held", {31'b0, i2s_sdo_oe}, 32'h0);
    wr_reg(2, 32'h0); count_toggles(n); chk("R2 all off", 32'(n), 32'd0);
    wr_reg(2, 32'h1); count_toggles(n); chk("R2 R3 running toggles", 32'(n), 32'd20);
    wr_reg(2, 32'h2);

    run_case(0, 16, 0, 0, 0, 0, 1, 1, 0, 1, 4, 1);
    run_case(1, 24, 0, 0, 1, 0, 1, 1, 1, 0, 3, 0);
    run_case(2,  8, 0, 0, 1, 0, 1, 1, 0, 0, 4, 0);
    run_case(2, 18, 1, 1, 1, 0, 1, 1, 1, 0, 2, 1);
    run_case(0, 20, 0, 0, 0, 1, 1, 1, 1, 0, 4, 0);
    run_case(1, 16, 0, 0, 1, 0, 0, 1, 0, 0, 2, 0);
    run_case(0, 24, 1, 0, 1, 0, 1, 0, 0, 0, 4, 0);
    for (int i = 0; i < 8; i++)
      run_case(int'($urandom % 3), wl[$urandom % 5], 1'($urandom), 1'($urandom), 1, 0,
               1, 1, 1'($urandom), 0, 1 + int'($urandom % 4), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule